// File: doc/BRIEF.md
# Interrupt distribution unit

This block steers a set of common, level-sensitive interrupt lines to the cores of a multi-core cluster. Every common interrupt owns three pieces of configuration: a destination set (one bit per core), a mode word selecting the distribution policy, and a block bit. A single command port writes them, one command per cycle. The same port also carries a unit-wide enable. Until that enable is set, nothing reaches any core.

Each interrupt is delivered in one of two ways. In fixed delivery it always goes to a single core, which is the lowest-numbered core in its destination set. In round-robin delivery each new assertion is handed to the next core of the destination set, wrapping around after the last one. The chosen core keeps the request until the request stops being deliverable. The output is a flat vector with one line per core per interrupt, and it is registered.

Top module: `irq_distributor`

## Requirements
- R1: After reset every output is 0. All interrupts start blocked, every destination set starts empty and the unit starts disabled, so raising inputs before any command delivers nothing.
- R2: A command is sampled on a clock edge with `cmd_valid` high and acts from the following cycle. The opcodes are: 0 writes the destination set from `cmd_data[NUM_CORE-1:0]`, 1 writes the mode word, 2 writes the block bit from `cmd_data[0]`, and 3 writes the unit enable from `cmd_data[0]`. Opcodes 0 to 2 apply to interrupt `cmd_idx`.
- R3: While the unit enable is 0, every output is 0 on the following edge.
- R4: Block bit 1 stops an interrupt and 0 releases it. An interrupt whose input is high when it is released is delivered at the second clock edge after the release command is sampled, using the configuration in force at that time.
- R5: With mode bits [1:0] other than 2 (0 is the fixed encoding), a deliverable interrupt goes to the lowest-numbered core in its destination set.
- R6: With mode bits [1:0] = 2 (round-robin), the first grant after reset goes to the lowest core in the set. The granted core is held for as long as the interrupt stays deliverable and that core stays in the set.
- R7: In round-robin mode a new grant goes to the first set bit strictly above the previously granted core, wrapping from the top core to core 0.
- R8: An interrupt with an empty destination set reaches no core.
- R9: Output `core_irq[c*NUM_IRQ+i]` is a registered copy of the decision for interrupt i at core c, made from the inputs and configuration of the previous cycle. It falls one edge after the input falls.
- R10: For any interrupt, at most one core line is high at a time.
- R11: Mode word bits other than [1:0] are ignored. Bit 4, the level-trigger flag, is accepted, and level behaviour is the only behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command opcode |
| cmd_idx | input | IDX_W | Target interrupt index |
| cmd_data | input | DATA_W | Command payload |
| irq_in | input | NUM_IRQ | Level inputs of the common interrupts |
| core_irq | output | NUM_CORE*NUM_IRQ | Per-core, per-interrupt request lines (core-major) |

## Verification
Every core line is due exactly one edge after the input and configuration it depends on. A command therefore shows at the second edge after it is sampled: the first edge writes the register and the second edge registers the output. The bench drives stimulus just after an edge. Before that edge it computes the expected vector from a model holding the pre-edge configuration, and it compares 1 ns after the edge. Directed corners spell out the two-edge latency of release and disable commands, and the round-robin order over several input pulses.

// File: rtl/idu_pkg.sv
`timescale 1ns/1ps
package idu_pkg;
   typedef enum logic [1:0] {
      OP_DEST   = 2'd0,
      OP_MODE   = 2'd1,
      OP_MASK   = 2'd2,
      OP_ENABLE = 2'd3
   } idu_op_e;

   localparam logic [1:0] POL_FIXED = 2'd0;
   localparam logic [1:0] POL_RR    = 2'd2;
   localparam int         MODE_LVL_BIT = 4;
endpackage

// File: rtl/idu_cfg.sv
`timescale 1ns/1ps
module idu_cfg #(
   parameter int NUM_IRQ  = 8,
   parameter int NUM_CORE = 4,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 3
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               cmd_valid,
   input  logic [1:0]                         cmd_op,
   input  logic [IDX_W-1:0]                   cmd_idx,
   input  logic [DATA_W-1:0]                  cmd_data,
   output logic                               en_o,
   output logic [NUM_IRQ-1:0]                 mask_o,
   output logic [NUM_IRQ-1:0][NUM_CORE-1:0]   dest_o,
   output logic [NUM_IRQ-1:0][1:0]            pol_o
);
   import idu_pkg::*;

   logic unused_data_bits;
   assign unused_data_bits = ^cmd_data;

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_o <= 1'b0;
      else if (cmd_valid && cmd_op == OP_ENABLE)
         en_o <= cmd_data[0];
   end

   for (genvar g = 0; g < NUM_IRQ; g++) begin : slot_g
      logic hit;
      assign hit = cmd_valid && (cmd_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_o[g] <= 1'b1;
            dest_o[g] <= '0;
            pol_o[g]  <= POL_FIXED;
         end else if (hit) begin
            case (cmd_op)
               OP_DEST: dest_o[g]  <= cmd_data[NUM_CORE-1:0];
               OP_MODE: pol_o[g]   <= cmd_data[1:0];
               OP_MASK: mask_o[g]  <= cmd_data[0];
               default: ;
            endcase
         end
      end
   end

   // R1
   reset_blocked_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (mask_o == '1 && !en_o));
endmodule

// File: rtl/idu_channel.sv
`timescale 1ns/1ps
module idu_channel #(
   parameter int NUM_CORE = 4,
   parameter int CW       = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic                mask_i,
   input  logic [NUM_CORE-1:0] dest_i,
   input  logic [1:0]          pol_i,
   input  logic                irq_i,
   output logic [NUM_CORE-1:0] out_o
);
   import idu_pkg::*;

   logic          active, is_rr, keep;
   logic [CW-1:0] low_idx, nxt_idx, rr_idx, last_q;
   logic          hold_q;
   logic [NUM_CORE-1:0] nxt_out;

   always_comb begin
      active  = en_i && !mask_i && irq_i && (|dest_i);
      is_rr   = (pol_i == POL_RR);
      low_idx = '0;
      for (int j = NUM_CORE - 1; j >= 0; j--)
         if (dest_i[j]) low_idx = CW'(j);
      nxt_idx = '0;
      for (int k = NUM_CORE; k >= 1; k--)
         if (dest_i[(int'(last_q) + k) % NUM_CORE])
            nxt_idx = CW'((int'(last_q) + k) % NUM_CORE);
      keep    = hold_q && dest_i[last_q];
      rr_idx  = keep ? last_q : nxt_idx;
      nxt_out = '0;
      if (active)
         nxt_out[is_rr ? rr_idx : low_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_o  <= '0;
         hold_q <= 1'b0;
         last_q <= CW'(NUM_CORE - 1);
      end else begin
         out_o  <= nxt_out;
         hold_q <= active && is_rr;
         if (active && is_rr)
            last_q <= rr_idx;
      end
   end

   // R10
   one_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_o));
   // R3
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (out_o == '0));
   // R4
   blocked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_i |=> (out_o == '0));
   // R9
   input_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_i |=> (out_o == '0));
   // R8
   in_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_o != '0) |-> ((out_o & ~$past(dest_i)) == '0));
   // R6
   rr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_q && dest_i[last_q] && active && is_rr) |=> $stable(out_o));
endmodule

// File: rtl/irq_distributor.sv
`timescale 1ns/1ps
module irq_distributor #(
   parameter int NUM_IRQ  = 8,
   parameter int NUM_CORE = 4,
   parameter int DATA_W   = 32,
   parameter int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [1:0]                   cmd_op,
   input  logic [IDX_W-1:0]             cmd_idx,
   input  logic [DATA_W-1:0]            cmd_data,
   input  logic [NUM_IRQ-1:0]           irq_in,
   output logic [NUM_CORE*NUM_IRQ-1:0]  core_irq
);
   localparam int CW = $clog2(NUM_CORE);

   if (NUM_CORE < 2) begin : bad_core_g
      $error("NUM_CORE must be at least 2");
   end
   if (NUM_IRQ < 1 || (1 << IDX_W) < NUM_IRQ) begin : bad_irq_g
      $error("IDX_W too narrow for NUM_IRQ");
   end
   if (DATA_W < NUM_CORE || DATA_W < 5) begin : bad_data_g
      $error("DATA_W must hold a core set and the mode word");
   end

   logic                             en;
   logic [NUM_IRQ-1:0]               mask;
   logic [NUM_IRQ-1:0][NUM_CORE-1:0] dest;
   logic [NUM_IRQ-1:0][1:0]          pol;
   logic [NUM_IRQ-1:0][NUM_CORE-1:0] ch_out;

   idu_cfg #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data),
      .en_o(en), .mask_o(mask), .dest_o(dest), .pol_o(pol)
   );

   for (genvar i = 0; i < NUM_IRQ; i++) begin : ch_g
      idu_channel #(.NUM_CORE(NUM_CORE), .CW(CW)) u_ch (
         .clk(clk), .rst_n(rst_n), .en_i(en), .mask_i(mask[i]),
         .dest_i(dest[i]), .pol_i(pol[i]), .irq_i(irq_in[i]),
         .out_o(ch_out[i])
      );
   end

   always_comb begin
      for (int c = 0; c < NUM_CORE; c++)
         for (int i = 0; i < NUM_IRQ; i++)
            core_irq[c*NUM_IRQ + i] = ch_out[i][c];
   end
endmodule

// File: tb/sim_irq_distributor.sv
`timescale 1ns/1ps
module sim_irq_distributor;
   localparam int NI = 8;
   localparam int NC = 4;
   localparam int DW = 32;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = '0;
   logic [IW-1:0] cmd_idx = '0;
   logic [DW-1:0] cmd_data = '0;
   logic [NI-1:0] irq_in = '0;
   logic [NC*NI-1:0] core_irq;

   irq_distributor #(.NUM_IRQ(NI), .NUM_CORE(NC), .DATA_W(DW), .IDX_W(IW)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in), .core_irq(core_irq)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int fails  = 0;
   logic done = 1'b0;

   // model state
   logic          m_en;
   logic          m_mask [NI];
   logic [NC-1:0] m_dest [NI];
   logic [1:0]    m_pol  [NI];
   int            m_last [NI];
   logic          m_hold [NI];
   logic [NC*NI-1:0] exp_v;

   function automatic int lowest(logic [NC-1:0] d);
      for (int j = 0; j < NC; j++) if (d[j]) return j;
      return -1;
   endfunction

   function automatic int after(logic [NC-1:0] d, int prev);
      for (int k = 1; k <= NC; k++) if (d[(prev + k) % NC]) return (prev + k) % NC;
      return -1;
   endfunction

   task automatic check(string tag, logic [NC*NI-1:0] got, logic [NC*NI-1:0] want);
      checks++;
      if (got !== want) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", tag, got, want);
      end
   endtask

   function automatic logic [NC-1:0] column(logic [NC*NI-1:0] v, int i);
      logic [NC-1:0] r;
      for (int c = 0; c < NC; c++) r[c] = v[c*NI + i];
      return r;
   endfunction

   task automatic model_reset();
      m_en = 1'b0;
      for (int i = 0; i < NI; i++) begin
         m_mask[i] = 1'b1; m_dest[i] = '0; m_pol[i] = 2'd0;
         m_last[i] = NC - 1; m_hold[i] = 1'b0;
      end
      exp_v = '0;
   endtask

   // one cycle: model from pre-edge state, then compare after edge
   task automatic step(string tag);
      logic [NC*NI-1:0] e;
      e = '0;
      for (int i = 0; i < NI; i++) begin
         logic act, rr;
         int idx;
         act = m_en && !m_mask[i] && irq_in[i] && (m_dest[i] != '0);
         rr  = (m_pol[i] == 2'd2);
         if (act) begin
            if (rr) begin
               idx = (m_hold[i] && m_dest[i][m_last[i]]) ? m_last[i] : after(m_dest[i], m_last[i]);
               m_last[i] = idx;
            end else idx = lowest(m_dest[i]);
            e[idx*NI + i] = 1'b1;
         end
         m_hold[i] = act && rr;
      end
      if (cmd_valid) begin
         case (cmd_op)
            2'd0: m_dest[cmd_idx] = cmd_data[NC-1:0];
            2'd1: m_pol[cmd_idx]  = cmd_data[1:0];
            2'd2: m_mask[cmd_idx] = cmd_data[0];
            default: m_en = cmd_data[0];
         endcase
      end
      exp_v = e;
      @(posedge clk); #1;
      cmd_valid = 1'b0;
      check(tag, core_irq, exp_v);
      for (int i = 0; i < NI; i++) begin
         checks++;
         if ($countones(column(core_irq, i)) > 1) begin
            fails++;
            $display("FAIL R10 irq %0d got=%b exp=onehot0", i, column(core_irq, i));
         end
      end
   endtask

   task automatic cmd(int op, int idx, int data, string tag);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_idx = IW'(idx); cmd_data = DW'(data);
      step(tag);
   endtask

   task automatic want_core(string tag, int i, int core);
      logic [NC-1:0] w;
      w = '0;
      if (core >= 0) w[core] = 1'b1;
      checks++;
      if (column(core_irq, i) !== w) begin
         fails++;
         $display("FAIL %s irq %0d got=%b exp=%b", tag, i, column(core_irq, i), w);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog got=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check("R1 reset", core_irq, '0);
      irq_in = '1;
      step("R1 blocked at reset");
      want_core("R1", 0, -1);

      // fixed delivery, disabled unit first
      cmd(0, 0, 4'b0110, "R2 dest");
      cmd(2, 0, 0, "R2 unblock");
      step("R3 disabled");
      want_core("R3", 0, -1);
      cmd(3, 0, 1, "R2 enable");
      want_core("R3 enable edge", 0, -1);
      step("R5 fixed");
      want_core("R5 lowest bit", 0, 1);
      cmd(1, 0, 32'hFFFF_FF10, "R11 mode junk");
      step("R11");
      want_core("R11 fixed with level bit", 0, 1);

      // empty destination
      cmd(2, 1, 0, "R8 unblock");
      step("R8 empty");
      want_core("R8", 1, -1);

      // block / release while input high
      cmd(2, 0, 1, "R4 block");
      want_core("R4 block first edge", 0, 1);
      step("R4 blocked");
      want_core("R4 blocked", 0, -1);
      cmd(2, 0, 0, "R4 release");
      want_core("R4 release first edge", 0, -1);
      step("R4 release");
      want_core("R4 second edge", 0, 1);

      // disable stops output
      cmd(3, 0, 0, "R3 disable");
      step("R3 off");
      want_core("R3 off", 0, -1);
      cmd(3, 0, 1, "R2 re-enable");

      // round robin with dest 1011
      irq_in[2] = 1'b0;
      cmd(0, 2, 4'b1011, "R2 dest rr");
      cmd(1, 2, 32'h0000_00FE, "R11 rr junk");
      cmd(2, 2, 0, "R6 unblock");
      begin
         int order [4] = '{0, 1, 3, 0};
         for (int p = 0; p < 4; p++) begin
            irq_in[2] = 1'b1;
            for (int h = 0; h < 3; h++) begin
               step("R6 hold");
               want_core(p == 0 ? "R6 first" : "R7 next", 2, order[p]);
            end
            irq_in[2] = 1'b0;
            step("R9 fall");
            want_core("R9 falls next edge", 2, -1);
         end
      end

      // random phase
      for (int n = 0; n < 4000; n++) begin
         irq_in = NI'($urandom);
         if ($urandom_range(0, 3) == 0) begin
            int op;
            int d;
            op = $urandom_range(0, 3);
            d  = $urandom;
            if (op == 3) d = ($urandom_range(0, 9) != 0);
            if (op == 2) d = ($urandom_range(0, 3) == 0);
            if (op == 1) d = ($urandom_range(0, 1) != 0) ? (d | 2) & ~1 : d;
            cmd_valid = 1'b1; cmd_op = 2'(op); cmd_idx = IW'($urandom); cmd_data = DW'(d);
         end
         step("R9 random vs model");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule